// File: doc/BRIEF.md
# Acquisition Timebase with Clock Fallback and Trigger Qualification

This block produces the timebase shared by every sampling channel. It watches an external 2 MHz sample clock for activity. Once that clock has shown a steady rhythm, the block takes its tick from the external clock's rising edges. When the external clock goes quiet, the block returns on its own to an internal divider that runs at the same rate. It also keeps a free-running timestamp that advances by one on every tick. At the default width of 32 bits, one count is 500 ns and the counter spans a little over 30 minutes before it wraps.

The timestamp returns to zero on a trigger, which can come from two places. One is an active-low external trigger line, which is accepted only after it has stayed low for the minimum width after a falling edge. The other is a software write to the command word with the trigger bit set. A software trigger acts once per write and is never stored. The ports report the tick strobe, the timestamp, the clock source in use and a one-cycle pulse for each accepted trigger. All logic runs in one fast system clock domain. The external clock and trigger pass through a two-flop synchronizer before they are used.

Top module: `tt_timebase`

## Requirements
- R1: After reset `tick_o`, `trig_o` and `time_o` are 0, and `src_ext_o` is 0, meaning the internal source is in use.
- R2: While the internal source is in use, `tick_o` pulses for one cycle every `TICK_DIV` system cycles.
- R3: `time_o` goes up by one with every `tick_o` pulse and changes at no other time except a trigger. It wraps from all ones to 0.
- R4: The external clock is selected (`src_ext_o` = 1) on the rising edge that completes `LOCK_EDGES` consecutive edge spacings, each within `TICK_DIV`±`TOL` cycles. From then on, ticks follow the external rising edges.
- R5: An external clock whose edge spacing lies outside `TICK_DIV`±`TOL` is never selected, and the internal ticks carry on unchanged.
- R6: If no external rising edge arrives for `LOSS_CYC` cycles, `src_ext_o` returns to 0. The first internal tick then comes exactly `TICK_DIV` cycles after `src_ext_o` falls.
- R7: Two `tick_o` pulses are never closer than `TICK_DIV/2` cycles, and this holds across source switches too.
- R8: If `ext_trig_ni` stays low for `MIN_LOW` system cycles after a falling edge, exactly one `trig_o` pulse follows, with `time_o` = 0 in the same cycle. A low pulse one cycle shorter produces no trigger, and so does a held-low level with no falling edge.
- R9: A cycle with `cmd_wr_i` = 1 and bit 24 of `cmd_wdata_i` set produces exactly one `trig_o` pulse on the next clock. A write with bit 24 clear, or bit 24 set while `cmd_wr_i` = 0, produces no trigger.
- R10: When a trigger and a tick land in the same cycle, the trigger wins and `time_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_clk_i | input | 1 | External 2 MHz sample clock (asynchronous) |
| ext_trig_ni | input | 1 | External trigger, active low (asynchronous) |
| cmd_wr_i | input | 1 | Command word write strobe |
| cmd_wdata_i | input | 32 | Command word; bit 24 requests a software trigger |
| tick_o | output | 1 | One-cycle sample tick strobe |
| time_o | output | CNT_W | Timestamp in tick units |
| src_ext_o | output | 1 | 1 = external clock in use, 0 = internal divider |
| trig_o | output | 1 | One-cycle pulse for each accepted trigger |

## Verification
If the edge-spacing or silence counters in the clock monitor hold a wrong value, `src_ext_o` changes at the wrong edge. That error shows one external period early or late at lock, or away from the `LOSS_CYC` mark at loss. A wrong divider phase shows at once in the tick spacing, both in internal mode and in the first tick after fallback. A wrong low-width count in the trigger qualifier either passes a pulse one cycle too short or misses one that is long enough. Each of these shows up as a missing or extra `trig_o` within a few cycles of the trigger's rising edge. Any timestamp fault breaks the one-step-per-tick rule at the next tick.

// File: rtl/tt_pkg.sv
package tt_pkg;
  typedef enum logic {
    SRC_INT = 1'b0,
    SRC_EXT = 1'b1
  } clk_src_e;

  localparam int SW_TRIG_BIT = 24;
endpackage

// File: rtl/tt_sync.sv
module tt_sync #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/tt_clk_mon.sv
module tt_clk_mon #(
  parameter int TICK_DIV   = 50,
  parameter int TOL        = 5,
  parameter int LOSS_CYC   = 400,
  parameter int LOCK_EDGES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clk_sync_i,
  output logic edge_o,
  output logic ext_ok_o
);
  localparam int SW = $clog2(LOSS_CYC + 1);
  localparam int GW = $clog2(LOCK_EDGES + 1);
  localparam logic [SW-1:0] SINCE_MAX  = SW'(LOSS_CYC);
  localparam logic [SW-1:0] SINCE_LOSS = SW'(LOSS_CYC - 1);
  localparam logic [SW:0]   WIN_LO     = (SW+1)'(TICK_DIV - TOL);
  localparam logic [SW:0]   WIN_HI     = (SW+1)'(TICK_DIV + TOL);
  localparam logic [GW-1:0] GOOD_MAX   = GW'(LOCK_EDGES);
  localparam logic [GW-1:0] GOOD_LOCK  = GW'(LOCK_EDGES - 1);

  logic          prev_q;
  logic [SW-1:0] since_q;
  logic [GW-1:0] good_q;
  logic          ok_q;
  logic [SW:0]   spacing;
  logic          in_win, lose, lock;

  assign edge_o  = clk_sync_i & ~prev_q;
  assign spacing = {1'b0, since_q} + (SW+1)'(1);
  assign in_win  = (spacing >= WIN_LO) && (spacing <= WIN_HI);
  assign lose    = ok_q & ~edge_o & (since_q == SINCE_LOSS);
  assign lock    = ~ok_q & edge_o & in_win & (good_q == GOOD_LOCK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      since_q <= SINCE_MAX;
      good_q  <= '0;
      ok_q    <= 1'b0;
    end else begin
      prev_q <= clk_sync_i;
      if (edge_o)                  since_q <= '0;
      else if (since_q != SINCE_MAX) since_q <= since_q + SW'(1);

      if (lose)                    good_q <= '0;
      else if (edge_o) begin
        if (!in_win)               good_q <= '0;
        else if (good_q != GOOD_MAX) good_q <= good_q + GW'(1);
      end

      if (lock)      ok_q <= 1'b1;
      else if (lose) ok_q <= 1'b0;
    end
  end

  assign ext_ok_o = ok_q;

  AST_LOSS_AFTER_SILENCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ok_q) |-> $past(since_q) == SINCE_LOSS); // R6
  AST_LOCK_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ok_q) |-> $past(edge_o) && $past(good_q) == GOOD_LOCK); // R4
endmodule

// File: rtl/tt_trig_qual.sv
module tt_trig_qual #(
  parameter int MIN_LOW = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_sync_ni,
  output logic fire_o
);
  localparam int LW = $clog2(MIN_LOW + 1);
  localparam logic [LW-1:0] LOW_MAX = LW'(MIN_LOW);
  localparam logic [LW-1:0] LOW_HIT = LW'(MIN_LOW - 1);

  // starts saturated: a line held low out of reset has no falling edge
  logic [LW-1:0] low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 low_q <= LOW_MAX;
    else if (trig_sync_ni)       low_q <= '0;
    else if (low_q != LOW_MAX)   low_q <= low_q + LW'(1);
  end

  assign fire_o = ~trig_sync_ni & (low_q == LOW_HIT);

  AST_TRIG_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !fire_o); // R8
  AST_TRIG_HELD_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> $past(!trig_sync_ni)); // R8
endmodule

// File: rtl/tt_tick_gen.sv
module tt_tick_gen #(
  parameter int TICK_DIV = 50,
  parameter int MIN_GAP  = 25
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_edge_i,
  input  logic use_ext_i,
  output logic tick_d_o,
  output logic tick_o
);
  localparam int DW = $clog2(TICK_DIV);
  localparam int GW = $clog2(MIN_GAP + 1);
  localparam logic [DW-1:0] DIV_LAST = DW'(TICK_DIV - 1);
  localparam logic [GW-1:0] GAP_MAX  = GW'(MIN_GAP);
  localparam logic [GW-1:0] GAP_ARM  = GW'(MIN_GAP - 1);

  logic [DW-1:0] div_q;
  logic [GW-1:0] gap_q;
  logic          tick_q;
  logic          wrap, raw;

  assign wrap     = ~use_ext_i & (div_q == DIV_LAST);
  assign raw      = use_ext_i ? ext_edge_i : wrap;
  // spacing guard suppresses a second tick around a source switch
  assign tick_d_o = raw & (gap_q >= GAP_ARM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      gap_q  <= GAP_MAX;
      tick_q <= 1'b0;
    end else begin
      // divider parked at zero while external source rules
      if (use_ext_i || wrap) div_q <= '0;
      else                   div_q <= div_q + DW'(1);

      if (tick_d_o)              gap_q <= '0;
      else if (gap_q != GAP_MAX) gap_q <= gap_q + GW'(1);

      tick_q <= tick_d_o;
    end
  end

  assign tick_o = tick_q;

  AST_EXT_NO_INT_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (use_ext_i && !ext_edge_i) |=> !tick_q); // R4
endmodule

// File: rtl/tt_timebase.sv
module tt_timebase
  import tt_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int TICK_DIV   = 50,
  parameter int TOL        = 5,
  parameter int LOSS_CYC   = 400,
  parameter int LOCK_EDGES = 8,
  parameter int MIN_LOW    = 50
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_clk_i,
  input  logic             ext_trig_ni,
  input  logic             cmd_wr_i,
  input  logic [31:0]      cmd_wdata_i,
  output logic             tick_o,
  output logic [CNT_W-1:0] time_o,
  output logic             src_ext_o,
  output logic             trig_o
);
  localparam int MIN_GAP = TICK_DIV / 2;

  logic       clk_s, trig_s;
  logic       ext_edge, ext_ok, ext_fire;
  logic       tick_d, sw_trig, trig_d, trig_q;
  logic       unused_wdata;
  clk_src_e   src;
  logic [CNT_W-1:0] cnt_q;

  tt_sync #(.W(2), .RST_VAL(2'b10)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ext_trig_ni, ext_clk_i}),
    .q_o   ({trig_s, clk_s})
  );

  tt_clk_mon #(
    .TICK_DIV  (TICK_DIV),
    .TOL       (TOL),
    .LOSS_CYC  (LOSS_CYC),
    .LOCK_EDGES(LOCK_EDGES)
  ) u_clk_mon (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clk_sync_i(clk_s),
    .edge_o    (ext_edge),
    .ext_ok_o  (ext_ok)
  );

  tt_trig_qual #(.MIN_LOW(MIN_LOW)) u_trig_qual (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .trig_sync_ni(trig_s),
    .fire_o      (ext_fire)
  );

  tt_tick_gen #(.TICK_DIV(TICK_DIV), .MIN_GAP(MIN_GAP)) u_tick_gen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ext_edge_i(ext_edge),
    .use_ext_i (ext_ok),
    .tick_d_o  (tick_d),
    .tick_o    (tick_o)
  );

  assign src          = clk_src_e'(ext_ok);
  assign src_ext_o    = (src == SRC_EXT);
  assign sw_trig      = cmd_wr_i & cmd_wdata_i[SW_TRIG_BIT];
  assign unused_wdata = ^{cmd_wdata_i[31:SW_TRIG_BIT+1], cmd_wdata_i[SW_TRIG_BIT-1:0]};
  assign trig_d       = ext_fire | sw_trig;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      trig_q <= trig_d;
      if (trig_d)      cnt_q <= '0;        // trigger beats a coincident tick
      else if (tick_d) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign trig_o = trig_q;
  assign time_o = cnt_q;

  // spacing watch for tick_o, independent of the generator's own guard
  localparam int GCW = $clog2(TICK_DIV + 1);
  localparam logic [GCW-1:0] GCHK_MAX = GCW'(TICK_DIV);
  localparam logic [GCW-1:0] GCHK_MIN = GCW'(MIN_GAP - 1);
  logic [GCW-1:0] chk_gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    chk_gap_q <= GCHK_MAX;
    else if (tick_o)                chk_gap_q <= '0;
    else if (chk_gap_q != GCHK_MAX) chk_gap_q <= chk_gap_q + GCW'(1);
  end

  AST_TICK_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> chk_gap_q >= GCHK_MIN); // R7
  AST_TRIG_ZEROES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> time_o == '0); // R10
  AST_TIME_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trig_o && !tick_o) |-> $stable(time_o)); // R3
  AST_TIME_STEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !trig_o) |-> time_o == $past(time_o) + CNT_W'(1)); // R3
endmodule

// File: tb/tt_timebase_bench.sv
module tt_timebase_bench;
  localparam int CLK_PERIOD   = 10;
  localparam int P_CNT_W      = 8;
  localparam int P_TICK_DIV   = 10;
  localparam int P_TOL        = 2;
  localparam int P_LOSS_CYC   = 80;
  localparam int P_LOCK_EDGES = 8;
  localparam int P_MIN_LOW    = 10;
  localparam logic [31:0] TRIG_WORD = 32'h0100_0000;  // bit 24

  logic clk = 1'b0, rst_n = 1'b0;
  logic ext_clk = 1'b0, ext_trig_n = 1'b1;
  logic cmd_wr = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic tick_o, src_ext_o, trig_o;
  logic [P_CNT_W-1:0] time_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  tt_timebase #(
    .CNT_W(P_CNT_W), .TICK_DIV(P_TICK_DIV), .TOL(P_TOL),
    .LOSS_CYC(P_LOSS_CYC), .LOCK_EDGES(P_LOCK_EDGES), .MIN_LOW(P_MIN_LOW)
  ) u_tt_timebase (
    .clk_i(clk), .rst_ni(rst_n), .ext_clk_i(ext_clk), .ext_trig_ni(ext_trig_n),
    .cmd_wr_i(cmd_wr), .cmd_wdata_i(cmd_wdata),
    .tick_o(tick_o), .time_o(time_o), .src_ext_o(src_ext_o), .trig_o(trig_o)
  );

  int checks = 0, fails = 0, cyc = 0, last_tick_cyc = -1, last_gap = 0, trig_seen = 0;
  logic [P_CNT_W-1:0] model = '0;
  string exp_q[$];
  bit done = 0;
  bit ext_en = 0;
  int ext_hi = 5, ext_lo = 5, edges = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops expected triggers, tracks timestamp model and tick spacing
  always @(negedge clk) begin
    if (rst_n) begin
      string tag;
      cyc++;
      if (trig_o) begin
        trig_seen++;
        if (exp_q.size() == 0) chk(1'b0, "R8/R9 unexpected trigger", 1, 0);
        else begin
          tag = exp_q.pop_front();
          chk(time_o == '0, tag, time_o, 0);
        end
        model = '0;
      end else if (tick_o) begin
        model = model + 1'b1;
        chk(time_o == model, "R3 step", time_o, model);
      end else if (time_o != model) begin
        chk(1'b0, "R3 hold", time_o, model);
      end
      if (tick_o) begin
        if (last_tick_cyc >= 0) begin
          last_gap = cyc - last_tick_cyc;
          chk(last_gap >= P_TICK_DIV/2, "R7 spacing", last_gap, P_TICK_DIV/2);
        end
        last_tick_cyc = cyc;
      end
    end
  end

  // external clock driver
  initial forever begin
    @(negedge clk);
    if (ext_en) begin
      ext_clk = 1'b1;
      edges++;
      repeat (ext_hi) @(negedge clk);
      ext_clk = 1'b0;
      repeat (ext_lo - 1) @(negedge clk);
    end else ext_clk = 1'b0;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  task automatic wait_ticks(input int n);
    repeat (n) begin
      do @(negedge clk); while (!tick_o);
    end
    #1;
  endtask

  task automatic drain(input string req);
    repeat (30) @(negedge clk);
    #1;
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  task automatic sw_write(input logic [31:0] data, input bit expect_trig);
    @(negedge clk);
    if (expect_trig) exp_q.push_back("R9 sw trigger");
    cmd_wr = 1'b1; cmd_wdata = data;
    @(negedge clk);
    cmd_wr = 1'b0; cmd_wdata = '0;
  endtask

  task automatic ext_pulse(input int n);
    @(negedge clk);
    ext_trig_n = 1'b0;
    repeat (n) @(negedge clk);
    ext_trig_n = 1'b1;
  endtask

  initial begin
    int t0, k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(tick_o == 1'b0, "R1 tick", tick_o, 0);
    chk(trig_o == 1'b0, "R1 trig", trig_o, 0);
    chk(time_o == '0, "R1 time", time_o, 0);
    chk(src_ext_o == 1'b0, "R1 source", src_ext_o, 0);

    // R2 internal period
    wait_ticks(3);
    chk(last_gap == P_TICK_DIV, "R2 period", last_gap, P_TICK_DIV);

    // R3 wrap
    for (int i = 0; i < 300 && time_o != '1; i++) wait_ticks(1);
    chk(time_o == '1, "R3 reach max", time_o, 255);
    wait_ticks(1);
    chk(time_o == '0, "R3 wrap", time_o, 0);

    // R9 software trigger and ignored writes
    t0 = trig_seen;
    sw_write(TRIG_WORD, 1'b1);
    drain("R9 missing trigger");
    chk(trig_seen == t0 + 1, "R9 single", trig_seen - t0, 1);
    t0 = trig_seen;
    sw_write(32'hFEFF_FFFF, 1'b0);
    @(negedge clk);
    cmd_wdata = TRIG_WORD;
    repeat (5) @(negedge clk);
    cmd_wdata = '0;
    repeat (30) @(negedge clk);
    #1;
    chk(trig_seen == t0, "R9 ignored", trig_seen - t0, 0);

    // R10 trigger coincides with tick
    wait_ticks(1);
    repeat (P_TICK_DIV - 1) @(negedge clk);
    exp_q.push_back("R10 coincident");
    cmd_wr = 1'b1; cmd_wdata = TRIG_WORD;
    @(negedge clk);
    cmd_wr = 1'b0; cmd_wdata = '0;
    chk(tick_o && trig_o, "R10 tick+trig", {tick_o, trig_o}, 3);
    chk(time_o == '0, "R10 time", time_o, 0);
    drain("R10 queue");

    // R8 external trigger widths
    t0 = trig_seen;
    exp_q.push_back("R8 min width");
    ext_pulse(P_MIN_LOW);
    drain("R8 missing trigger");
    chk(trig_seen == t0 + 1, "R8 min width count", trig_seen - t0, 1);
    t0 = trig_seen;
    ext_pulse(P_MIN_LOW - 1);
    repeat (30) @(negedge clk);
    #1;
    chk(trig_seen == t0, "R8 short pulse", trig_seen - t0, 0);
    t0 = trig_seen;
    exp_q.push_back("R8 long pulse");
    ext_pulse(3 * P_MIN_LOW);
    drain("R8 long missing");
    chk(trig_seen == t0 + 1, "R8 long count", trig_seen - t0, 1);

    // R5 out-of-tolerance external clock
    edges = 0; ext_hi = 10; ext_lo = 10; ext_en = 1;
    while (edges < 12) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(src_ext_o == 1'b0, "R5 not selected", src_ext_o, 0);
    wait_ticks(2);
    chk(last_gap == P_TICK_DIV, "R5 internal kept", last_gap, P_TICK_DIV);
    ext_en = 0;
    repeat (P_LOSS_CYC + 20) @(negedge clk);

    // R4 lock
    edges = 0; ext_hi = 5; ext_lo = 6; ext_en = 1;
    while (edges < P_LOCK_EDGES) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(src_ext_o == 1'b0, "R4 before lock", src_ext_o, 0);
    while (edges < P_LOCK_EDGES + 1) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(src_ext_o == 1'b1, "R4 locked", src_ext_o, 1);
    wait_ticks(3);
    chk(last_gap == 11, "R4 external period", last_gap, 11);

    // R6 loss and fallback
    ext_en = 0;
    repeat (P_LOSS_CYC / 2) @(negedge clk);
    chk(src_ext_o == 1'b1, "R6 hold before timeout", src_ext_o, 1);
    k = 0;
    while (src_ext_o && k < 200) begin @(negedge clk); k++; end
    chk(src_ext_o == 1'b0, "R6 fallback", src_ext_o, 0);
    k = 0;
    do begin @(negedge clk); k++; end while (!tick_o && k < 100);
    chk(k == P_TICK_DIV, "R6 first internal tick", k, P_TICK_DIV);
    wait_ticks(3);
    chk(last_gap == P_TICK_DIV, "R6 internal resumed", last_gap, P_TICK_DIV);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule